// File: doc/BRIEF.md
# Chained-Counter Watchdog Timer

This peripheral holds a small bank of 64-bit down-counters behind a plain word-wide register bus. Each counter has its own 16-byte window with a control word and a reload value split into a low and a high word. A counter runs in one of two modes. In one-shot mode it starts when its enable bit goes from 0 to 1. In hardware-trigger mode it starts, or restarts, each time the end-of-count event of the counter just below it fires. A prescaler sets how many input clocks make up one count step.

The watchdog use chains two counters. Counter 1 runs in hardware-trigger mode and follows counter 0. Counter 0 is a one-shot holding a reload of zero, so clearing and then setting its enable bit makes an immediate end-of-count event that re-arms counter 1. A select register marks which counters may drive the reset output. When a selected counter reaches zero, the block emits a one-cycle reset pulse. Loading counter 1 with zero and kicking it forces that reset at once.

Top module: `chain_wdt`

## Requirements
- R1: The register windows sit at byte offset 16*i for counter i. Each window holds the control word at +0x0, the low reload word at +0x4 and the high reload word at +0x8. The select register is at 0x20. A read returns its data on `bus_rdata` in the cycle after `bus_rd`. The control word reads as {prescale[15:8], trigger[7:4], mode[3:2], active[1], enable[0]}, and the reload words read back as written.
- R2: After reset every control, reload and select field reads zero, and `wdt_rst_o` stays low.
- R3: In one-shot mode (mode 00), an enable 0->1 write with a reload of N>0 and an effective prescale of P sets the active flag. The end-of-count event then comes N*P clocks after the write edge, and the active flag clears at that event. The enable bit stays set.
- R4: A one-shot start with a reload of 0 produces the end-of-count event on the write edge itself and never sets the active flag. Writing enable 0 and then 1 produces the event again.
- R5: A prescale field of 0 or 1 behaves as 2. Any other value P makes the counter step once every P clocks.
- R6: In mode 11 with trigger 0x5, counter i loads its reload on every end-of-count event of counter i-1, even while it is already running. It ends reload*P clocks after that event. Any other trigger value never starts the counter.
- R7: A write to a reload word changes only the stored reload, never a count in progress. The new value applies from the next start.
- R8: While the active flag is set, writes to the mode, trigger and prescale fields are ignored. The enable bit always takes the written value, and clearing it stops the counter with no end-of-count event.
- R9: `wdt_rst_o` is a one-cycle pulse that rises one clock after an end-of-count event of a counter whose select bit is set (bit i for counter i). It never rises when the select register is 0.
- R10: Disabling counter 1, loading it with reload 0, re-enabling it in mode 11 with trigger 0x5, and kicking counter 0 raises `wdt_rst_o` two clocks after the kick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_addr | input | 6 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench sweeps reload 0..5 against prescale 0..4. A prescaler that honoured 0 or 1, or a zero reload that waited a full period, would move the measured pulse time off N*P+1. The chained sweep and a double kick mid-run show whether counter 1 restarts from its reload on every event of counter 0. A design that ignored a retrigger while active would fire 42 clocks after the first kick instead of the second. Reload writes during a run, field writes while active, and clearing enable are each checked by timing or by the absence of a pulse. A design that let these disturb the running count would fire early or at all. The forced-expiry path and a select register of zero show whether the reset is gated and one cycle wide.

// File: rtl/chain_wdt_pkg.sv
package chain_wdt_pkg;
  localparam int PRESC_W = 8;
  localparam int CTRL_W  = 8 + PRESC_W;

  localparam logic [1:0] MODE_ONESHOT = 2'b00;
  localparam logic [1:0] MODE_HWTRIG  = 2'b11;
  localparam logic [3:0] TRIG_PREV    = 4'h5;
  localparam logic [PRESC_W-1:0] PRESC_MIN = PRESC_W'(2);

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_LO   = 2'd1;
  localparam logic [1:0] OFS_HI   = 2'd2;
endpackage

// File: rtl/chain_wdt_presc.sv
module chain_wdt_presc
  import chain_wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] div_lim;

  always_comb begin
    div_lim = (presc < PRESC_MIN) ? PRESC_MIN : presc;
    tick    = run && (div_q == div_lim - PRESC_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + PRESC_W'(1);
    end
  end
endmodule

// File: rtl/chain_wdt_counter.sv
module chain_wdt_counter
  import chain_wdt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              prev_eoc,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0]  reload_o,
  output logic              eoc_o,
  output logic              active_o,
  output logic              en_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic               en_q, active_q, eoc_q;
  logic [1:0]         mode_q;
  logic [3:0]         trig_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   reload_q, cnt_q;

  logic w_en;
  logic [1:0] w_mode;
  logic en_rise, en_fall, start_os, start_hw, start, tick;

  always_comb begin
    w_en     = wdata[0];
    w_mode   = wdata[3:2];
    en_rise  = ctrl_we && w_en && !en_q;
    en_fall  = ctrl_we && !w_en;
    start_os = en_rise && (w_mode == MODE_ONESHOT);
    start_hw = en_q && !en_fall && (mode_q == MODE_HWTRIG) &&
               (trig_q == TRIG_PREV) && prev_eoc;
    start    = start_os || start_hw;
  end

  chain_wdt_presc u_presc (
    .clk   (clk),
    .rst   (rst),
    .clear (start),
    .run   (active_q),
    .presc (presc_q),
    .tick  (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      active_q <= 1'b0;
      eoc_q    <= 1'b0;
      mode_q   <= '0;
      trig_q   <= '0;
      presc_q  <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      eoc_q <= 1'b0;
      if (ctrl_we) begin
        en_q <= w_en;
        if (!active_q) begin
          mode_q  <= w_mode;
          trig_q  <= wdata[7:4];
          presc_q <= wdata[8 +: PRESC_W];
        end
      end
      if (lo_we) reload_q[DATA_W-1:0]     <= wdata;
      if (hi_we) reload_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];

      if (en_fall) begin
        active_q <= 1'b0;
      end else if (start) begin
        if (reload_q == '0) begin
          active_q <= 1'b0;
          eoc_q    <= 1'b1;
        end else begin
          cnt_q    <= reload_q;
          active_q <= 1'b1;
        end
      end else if (active_q && tick) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          active_q <= 1'b0;
          eoc_q    <= 1'b1;
        end
      end
    end
  end

  assign ctrl_rd  = {presc_q, trig_q, mode_q, active_q, en_q};
  assign reload_o = reload_q;
  assign eoc_o    = eoc_q;
  assign active_o = active_q;
  assign en_o     = en_q;
endmodule

// File: rtl/chain_wdt.sv
module chain_wdt
  import chain_wdt_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 64,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_o
);
  localparam int WIN_W = ADDR_W - 4;

  logic [WIN_W-1:0] win;
  logic [1:0]       ofs;
  logic             aligned;

  logic [CTRL_W-1:0] ctrl_rd [NUM_CNT];
  logic [CNT_W-1:0]  reload  [NUM_CNT];
  logic [NUM_CNT-1:0] eoc_vec, active_vec, en_vec;
  logic [NUM_CNT-1:0] sel_q;
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic               rst_pulse_q;

  assign win     = bus_addr[ADDR_W-1:4];
  assign ofs     = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic hit, prev;
    assign hit = bus_wr && aligned && (win == WIN_W'(g));
    if (g == 0) begin : g_head
      assign prev = 1'b0;
    end else begin : g_link
      assign prev = eoc_vec[g-1];
    end
    chain_wdt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .ctrl_we  (hit && ofs == OFS_CTRL),
      .lo_we    (hit && ofs == OFS_LO),
      .hi_we    (hit && ofs == OFS_HI),
      .wdata    (bus_wdata),
      .prev_eoc (prev),
      .ctrl_rd  (ctrl_rd[g]),
      .reload_o (reload[g]),
      .eoc_o    (eoc_vec[g]),
      .active_o (active_vec[g]),
      .en_o     (en_vec[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (win == WIN_W'(i)) begin
        case (ofs)
          OFS_CTRL: rd_mux = DATA_W'(ctrl_rd[i]);
          OFS_LO:   rd_mux = reload[i][DATA_W-1:0];
          OFS_HI:   rd_mux = DATA_W'(reload[i] >> DATA_W);
          default:  rd_mux = '0;
        endcase
      end
    end
    if (win == WIN_W'(NUM_CNT) && ofs == 2'd0) rd_mux = DATA_W'(sel_q);
    if (!aligned) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      rdata_q     <= '0;
      rst_pulse_q <= 1'b0;
    end else begin
      if (bus_wr && aligned && win == WIN_W'(NUM_CNT) && ofs == 2'd0)
        sel_q <= bus_wdata[NUM_CNT-1:0];
      if (bus_rd) rdata_q <= rd_mux;
      rst_pulse_q <= |(eoc_vec & sel_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign wdt_rst_o = rst_pulse_q;
endmodule

// File: rtl/chain_wdt_chk.sv
module chain_wdt_chk #(
  parameter int NUM_CNT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wdt_rst_o,
  input logic [NUM_CNT-1:0] eoc_vec,
  input logic [NUM_CNT-1:0] active_vec,
  input logic [NUM_CNT-1:0] en_vec,
  input logic [NUM_CNT-1:0] sel_q
);
  a_r2_reset_quiet: assert property (@(posedge clk)
    rst |=> (!wdt_rst_o && active_vec == '0 && sel_q == '0));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |=> !wdt_rst_o);

  a_r9_needs_select: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |-> $past(sel_q != '0));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_per
    a_r8_active_needs_en: assert property (@(posedge clk) disable iff (rst)
      active_vec[i] |-> en_vec[i]);

    a_r3_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(active_vec[i]) |-> (eoc_vec[i] || !en_vec[i]));
  end
endmodule

bind chain_wdt chain_wdt_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wdt_rst_o  (wdt_rst_o),
  .eoc_vec    (eoc_vec),
  .active_vec (active_vec),
  .en_vec     (en_vec),
  .sel_q      (sel_q)
);

// File: tb/sim_chain_wdt.sv
`timescale 1ns/1ps
module sim_chain_wdt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;

  localparam logic [5:0] A_CTRL0 = 6'h00, A_LO0 = 6'h04, A_HI0 = 6'h08;
  localparam logic [5:0] A_CTRL1 = 6'h10, A_LO1 = 6'h14, A_SEL = 6'h20;

  int n_chk = 0, n_bad = 0;
  longint cyc = 0, last_rise = -1, wr_cyc = 0;
  int rise_cnt = 0, hi_cnt = 0;
  logic prev_rst = 1'b0;

  chain_wdt u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wdt_rst_o) begin
      hi_cnt = hi_cnt + 1;
      if (!prev_rst) begin
        rise_cnt  = rise_cnt + 1;
        last_rise = cyc;
      end
    end
    prev_rst = wdt_rst_o;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // waits for a new reset pulse; delta = pulse cycle minus c0, or -1
  task automatic wait_pulse(input int limit, input longint c0, output longint delta);
    int base;
    base  = rise_cnt;
    delta = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk); #1;
      if (rise_cnt != base) begin
        delta = last_rise - c0;
        break;
      end
    end
  endtask

  task automatic kick();
    wr(A_CTRL0, 32'h0000_0000);
    wr(A_CTRL0, 32'h0000_0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    longint dl, c0, cb;
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    rd(A_CTRL0, d); check("R2 ctrl0", d, 0);
    rd(A_LO0, d);   check("R2 lo0", d, 0);
    rd(A_HI0, d);   check("R2 hi0", d, 0);
    rd(A_CTRL1, d); check("R2 ctrl1", d, 0);
    rd(A_SEL, d);   check("R2 sel", d, 0);
    check("R2 no reset pulse", rise_cnt, 0);

    // R1 map and readback
    wr(A_LO0, 32'hDEAD_BEEF); wr(A_HI0, 32'h1234_5678);
    rd(A_LO0, d); check("R1 lo0", d, 32'hDEAD_BEEF);
    rd(A_HI0, d); check("R1 hi0", d, 32'h1234_5678);
    wr(A_CTRL1, 32'h0000_035C);
    rd(A_CTRL1, d); check("R1 ctrl1 fields", d, 32'h035C);
    wr(A_SEL, 32'h2); rd(A_SEL, d); check("R1 sel", d, 2);
    wr(A_HI0, 32'h0);

    // R3 R4 R5 sweep on counter 0 selected directly
    wr(A_SEL, 32'h1);
    for (int p = 0; p <= 4; p++) begin
      for (int n = 0; n <= 5; n++) begin
        int pe;
        pe = (p < 2) ? 2 : p;
        wr(A_LO0, n);
        wr(A_CTRL0, p << 8);
        wr(A_CTRL0, (p << 8) | 1);
        c0 = wr_cyc;
        wait_pulse(60, c0, dl);
        check($sformatf("R3 R5 oneshot n=%0d p=%0d", n, p), dl, n * pe + 1);
      end
    end

    // R4 zero reload retoggle gives two events
    wr(A_LO0, 0); wr(A_CTRL0, 32'h0200);
    base = rise_cnt;
    wr(A_CTRL0, 32'h0201); wr(A_CTRL0, 32'h0200); wr(A_CTRL0, 32'h0201);
    repeat (3) @(negedge clk);
    check("R4 two zero-count events", rise_cnt - base, 2);
    rd(A_CTRL0, d); check("R4 never active", d, 32'h0201);

    // R3 active flag and R8 field writes ignored while active
    wr(A_LO0, 20); wr(A_CTRL0, 32'h0200); wr(A_CTRL0, 32'h0201);
    c0 = wr_cyc;
    rd(A_CTRL0, d); check("R3 active while running", d, 32'h0203);
    wr(A_CTRL0, 32'h04FD);
    wait_pulse(100, c0, dl);
    check("R8 fields held while active", dl, 41);
    rd(A_CTRL0, d); check("R3 R8 ctrl after end", d, 32'h0201);

    // R8 clearing enable stops without event
    wr(A_CTRL0, 32'h0200); wr(A_CTRL0, 32'h0201);
    c0 = wr_cyc;
    wr(A_CTRL0, 32'h0200);
    wait_pulse(80, c0, dl);
    check("R8 disable suppresses event", dl, -1);
    rd(A_CTRL0, d); check("R8 ctrl after disable", d, 32'h0200);

    // R7 reload write while running
    wr(A_LO0, 10); wr(A_CTRL0, 32'h0201);
    c0 = wr_cyc;
    wr(A_LO0, 3);
    wait_pulse(80, c0, dl);
    check("R7 running count untouched", dl, 21);
    wr(A_CTRL0, 32'h0200); wr(A_CTRL0, 32'h0201);
    c0 = wr_cyc;
    wait_pulse(80, c0, dl);
    check("R7 new reload on next start", dl, 7);

    // R6 chained sweep, counter 1 selected
    wr(A_SEL, 32'h2); wr(A_LO0, 0); wr(A_CTRL0, 0);
    for (int p = 2; p <= 3; p++) begin
      for (int n = 0; n <= 4; n++) begin
        wr(A_CTRL1, (p << 8) | 32'h5C);
        wr(A_LO1, n);
        wr(A_CTRL1, (p << 8) | 32'h5D);
        kick();
        c0 = wr_cyc;
        wait_pulse(60, c0, dl);
        check($sformatf("R6 chained n=%0d p=%0d", n, p), dl, n * p + 2);
      end
    end

    // R6 retrigger while running re-arms
    wr(A_CTRL1, 32'h025C); wr(A_LO1, 20); wr(A_CTRL1, 32'h025D);
    base = rise_cnt;
    kick();
    repeat (20) @(negedge clk);
    kick();
    cb = wr_cyc;
    wait_pulse(120, cb, dl);
    check("R6 kick re-arms", dl, 42);
    check("R6 single expiry", rise_cnt - base, 1);

    // R6 other trigger value never starts
    wr(A_CTRL1, 32'h020C); wr(A_LO1, 0); wr(A_CTRL1, 32'h020D);
    kick();
    c0 = wr_cyc;
    wait_pulse(30, c0, dl);
    check("R6 trigger 0 ignored", dl, -1);

    // R9 select gating
    wr(A_CTRL1, 32'h025C); wr(A_CTRL1, 32'h025D); wr(A_SEL, 32'h0);
    kick();
    c0 = wr_cyc;
    wait_pulse(30, c0, dl);
    check("R9 select zero blocks reset", dl, -1);
    rd(A_CTRL1, d); check("R9 counter1 expired idle", d, 32'h025D);
    wr(A_SEL, 32'h2); wr(A_CTRL1, 32'h025C);
    kick();
    c0 = wr_cyc;
    wait_pulse(30, c0, dl);
    check("R9 unselected counter0 blocked", dl, -1);

    // R10 forced expiry
    wr(A_LO1, 1000); wr(A_CTRL1, 32'h025D);
    base = rise_cnt;
    kick();
    repeat (10) @(negedge clk);
    wr(A_CTRL1, 32'h025C); wr(A_LO1, 0); wr(A_CTRL1, 32'h025D);
    check("R10 no early reset", rise_cnt - base, 0);
    kick();
    c0 = wr_cyc;
    wait_pulse(30, c0, dl);
    check("R10 forced expiry", dl, 2);

    repeat (4) @(negedge clk);
    check("R9 pulses one cycle wide", hi_cnt, rise_cnt);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule